// File: doc/BRIEF.md
# Floating-point status register unit

This block holds the 32-bit status and control word of a floating-point unit. It merges the exception flags reported by the arithmetic datapath into sticky bits. It also carries out the control operations that software issues against the word: setting or clearing one bit, loading a nibble from an immediate, loading selected nibbles from a data operand, and moving a nibble out to the condition register. After every operation it derives three summary bits in hardware. These are the invalid summary, the enabled-exception summary and the any-change summary. The first two can never be written directly.

Each decoded operation comes with a one-cycle `op_valid` strobe and completes at the next rising clock edge. The new status word, a condition-register field write (data, field index and enable) and a trap request all appear one cycle after the strobe. The arithmetic datapath, instruction decode and the condition register itself sit outside this block.

Bit positions below use the usual vector numbering, where bit 31 is the most significant bit. Bit 31 is the any-change summary and bit 30 is the enabled-exception summary. Bit 29 is the invalid summary. Bits 28..25 are the sticky overflow, underflow, divide-by-zero and inexact flags. The invalid causes sit at bits 24..19 and 10..8. Bits 18 and 17 are the rounded and inexact-fraction flags. Bits 16..12 hold the result class, and its compare code is bits 15..12. The enables for invalid, overflow, underflow, divide-by-zero and inexact are bits 7..3. The non-IEEE mode bit is bit 2 and the rounding mode is bits 1..0. Operation codes on `op_kind` are: 0 arithmetic flag merge, 1 set bit, 2 clear bit, 3 immediate nibble write, 4 masked nibble write, 5 copy nibble to condition register, 6 compare.

Top module: `fstat_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `status` is 0, `cr_we` is 0 and `trap_req` is 0.
- R2: An arithmetic merge (code 0) or a compare (code 6) ORs `exc_flags` into the word; no sticky bit is ever cleared by it.
- R3: After every operation, bit 29 equals the OR of the nine invalid-cause bits 24..19 and 10..8, whatever was written to bit 29.
- R4: After every operation, bit 30 is 1 exactly when some enable bit 7..3 is set together with its partner summary bit 29..25 (enable bit e pairs with bit e+22); a value written to bit 30 is discarded.
- R5: Bit 31 is set when the result differs from the directly written value in any of bits 29..19 or 10..8; otherwise it keeps the written value, so a clear of bit 31 persists when nothing changes.
- R6: Set bit (code 1) and clear bit (code 2) act on bit 31-`op_bit`; targeting bit 30 or 29 has no effect beyond the recomputation of R3 and R4.
- R7: Immediate write (code 3) places `op_imm` into bits 31-4k..28-4k with k = `op_nib`, leaving every other nibble unchanged.
- R8: Masked write (code 4) replaces bits 4i+3..4i with the same bits of `op_data[31:0]` for every set bit i of `op_fmask`; the value 0xFF replaces the whole word and `op_data[63:32]` is ignored.
- R9: Copy (code 5) writes nibble k = `op_nib` of the old word into condition-register field `op_crf`, then clears only those copied bits that lie in bit 31, bits 28..25 or the invalid causes; the other copied bits stay.
- R10: Compare (code 6) loads `cmp_cc` into bits 15..12 and writes that code into condition-register field `op_crf`.
- R11: With `op_rec` high, codes 0 to 4 write bits 31..28 of the new word into condition-register field 1; codes 5 and 6 ignore `op_rec`.
- R12: `trap_req` is high for exactly the one cycle after an operation whose result has bit 30 set.
- R13: While `op_valid` is low the word holds, `cr_we` is 0 and `trap_req` is 0, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 3 | Operation code |
| op_bit | input | 5 | Bit selector n for set/clear (acts on bit 31-n) |
| op_nib | input | 3 | Nibble selector k for immediate write and copy |
| op_imm | input | 4 | Immediate nibble |
| op_fmask | input | 8 | Nibble enable mask for masked write |
| op_data | input | 64 | Data operand; low 32 bits used |
| op_rec | input | 1 | Record form: copy top nibble to condition field 1 |
| op_crf | input | 3 | Destination condition-register field for copy and compare |
| exc_flags | input | 32 | Exception flags from the datapath |
| cmp_cc | input | 4 | Compare result code |
| status | output | 32 | Current status and control word |
| cr_we | output | 1 | Condition-register field write enable |
| cr_field | output | 3 | Condition-register field index |
| cr_data | output | 4 | Condition-register field data |
| trap_req | output | 1 | Enabled exception pending |

## Verification
The bench writes ones into the two derived summary bits through set-bit, immediate and masked writes. A design that stored those writes would then hold a stale invalid or trap summary. It loads an invalid cause through a masked write, and checks both that bit 31 rises because the invalid summary changed and that a cleared bit 31 stays clear when an operation changes nothing. A design that compared against the pre-operation word, or against nothing at all, would miss one of the two. Copy is run on nibbles that mix sticky and non-sticky bits, which exposes a design that clears the whole nibble. The trap request is then followed through an enable being set, the matching exception staying sticky, and the exception bit being cleared.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    localparam int WORD_W    = 32;
    localparam int NIB_W     = 4;
    localparam int NFIELD    = WORD_W / NIB_W;
    localparam int DATA_W    = 64;
    localparam int BIT_IDX_W = $clog2(WORD_W);
    localparam int FLD_IDX_W = $clog2(NFIELD);

    // bit positions, bit 31 is the most significant
    localparam int B_ANY   = 31;   // any-change summary
    localparam int B_TRAP  = 30;   // enabled-exception summary
    localparam int B_INV   = 29;   // invalid summary
    localparam int SUM_LO  = 25;   // overflow..inexact summaries run 28..25
    localparam int EN_HI   = 7;    // enables run 7..3
    localparam int EN_LO   = 3;
    localparam int NUM_EN  = EN_HI - EN_LO + 1;
    localparam int CC_LO   = 12;   // compare code 15..12
    localparam int CR_REC_FIELD = 1;

    localparam logic [WORD_W-1:0] INV_CAUSE_M = 32'h01F8_0700;
    localparam logic [WORD_W-1:0] EXC_STAT_M  = 32'h3FF8_0700;
    localparam logic [WORD_W-1:0] COPY_CLR_M  = 32'h9FF8_0700;
    localparam logic [WORD_W-1:0] DERIVED_M   = 32'h6000_0000;

    typedef enum logic [2:0] {
        OPK_ARITH = 3'd0,
        OPK_SETB  = 3'd1,
        OPK_CLRB  = 3'd2,
        OPK_IMM   = 3'd3,
        OPK_MASK  = 3'd4,
        OPK_COPY  = 3'd5,
        OPK_CMP   = 3'd6,
        OPK_RSVD  = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0]    stat;
        logic                 cr_we;
        logic [FLD_IDX_W-1:0] cr_fld;
        logic [NIB_W-1:0]     cr_nib;
        logic                 trap;
    } fstat_state_t;

endpackage

// File: rtl/fstat_fieldmask.sv
module fstat_fieldmask #(
    parameter int NF = 8,
    parameter int NW = 4
) (
    input  logic [NF-1:0]    sel_i,
    output logic [NF*NW-1:0] bits_o
);
    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign bits_o[i*NW +: NW] = {NW{sel_i[i]}};
    end
endmodule

// File: rtl/fstat_direct.sv
module fstat_direct
    import fstat_pkg::*;
(
    input  logic [WORD_W-1:0]    old_i,
    input  logic [2:0]           kind_i,
    input  logic [BIT_IDX_W-1:0] bit_i,
    input  logic [FLD_IDX_W-1:0] nib_i,
    input  logic [NIB_W-1:0]     imm_i,
    input  logic [WORD_W-1:0]    nib_mask_i,
    input  logic [WORD_W-1:0]    fld_mask_i,
    input  logic [WORD_W-1:0]    data_i,
    input  logic [WORD_W-1:0]    exc_i,
    input  logic [NIB_W-1:0]     cc_i,
    output logic [WORD_W-1:0]    base_o,
    output logic [WORD_W-1:0]    cx_o,
    output logic [NIB_W-1:0]     copy_nib_o
);
    logic [BIT_IDX_W-1:0] pos;
    logic [WORD_W-1:0]    one_bit;

    always_comb begin
        pos        = BIT_IDX_W'(WORD_W - 1) - bit_i;
        one_bit    = WORD_W'(1) << pos;
        copy_nib_o = old_i[(NFIELD - 1 - int'(nib_i)) * NIB_W +: NIB_W];
        base_o     = old_i;
        cx_o       = '0;
        case (op_kind_e'(kind_i))
            OPK_ARITH: cx_o = exc_i;
            OPK_SETB:  cx_o = one_bit & ~DERIVED_M;
            OPK_CLRB:  base_o = old_i & ~(one_bit & ~DERIVED_M);
            OPK_IMM:   base_o = (old_i & ~nib_mask_i) | ({NFIELD{imm_i}} & nib_mask_i);
            OPK_MASK:  base_o = (old_i & ~fld_mask_i) | (data_i & fld_mask_i);
            OPK_COPY:  base_o = old_i & ~(nib_mask_i & COPY_CLR_M);
            OPK_CMP: begin
                base_o[CC_LO +: NIB_W] = cc_i;
                cx_o                   = exc_i;
            end
            default: begin
                base_o = old_i;
                cx_o   = '0;
            end
        endcase
    end
endmodule

// File: rtl/fstat_summary.sv
module fstat_summary
    import fstat_pkg::*;
(
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] cx_i,
    output logic [WORD_W-1:0] final_o
);
    logic [WORD_W-1:0] work;
    logic [NUM_EN-1:0] en_vec;
    logic [NUM_EN-1:0] sum_vec;

    always_comb begin
        work          = (base_i & ~DERIVED_M) | cx_i;
        work[B_INV]   = |(work & INV_CAUSE_M);
        en_vec        = work[EN_HI:EN_LO];
        sum_vec       = work[SUM_LO + NUM_EN - 1:SUM_LO];
        work[B_TRAP]  = |(en_vec & sum_vec);
        if (|((work ^ base_i) & EXC_STAT_M)) begin
            work[B_ANY] = 1'b1;
        end
        final_o = work;
    end
endmodule

// File: rtl/fstat_unit.sv
module fstat_unit
    import fstat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [2:0]           op_kind,
    input  logic [4:0]           op_bit,
    input  logic [2:0]           op_nib,
    input  logic [3:0]           op_imm,
    input  logic [7:0]           op_fmask,
    input  logic [63:0]          op_data,
    input  logic                 op_rec,
    input  logic [2:0]           op_crf,
    input  logic [31:0]          exc_flags,
    input  logic [3:0]           cmp_cc,
    output logic [31:0]          status,
    output logic                 cr_we,
    output logic [2:0]           cr_field,
    output logic [3:0]           cr_data,
    output logic                 trap_req
);
    fstat_state_t state_d, state_q;

    logic [NFIELD-1:0] nib_onehot;
    logic [WORD_W-1:0] nib_mask;
    logic [WORD_W-1:0] fld_mask;
    logic [WORD_W-1:0] base_w;
    logic [WORD_W-1:0] cx_w;
    logic [WORD_W-1:0] final_w;
    logic [NIB_W-1:0]  copy_nib;
    logic              unused_hi;

    assign unused_hi  = ^op_data[DATA_W-1:WORD_W];
    assign nib_onehot = NFIELD'(1) << (FLD_IDX_W'(NFIELD - 1) - op_nib);

    fstat_fieldmask #(.NF(NFIELD), .NW(NIB_W)) u_nibmask (
        .sel_i  (nib_onehot),
        .bits_o (nib_mask)
    );

    fstat_fieldmask #(.NF(NFIELD), .NW(NIB_W)) u_fldmask (
        .sel_i  (op_fmask),
        .bits_o (fld_mask)
    );

    fstat_direct u_direct (
        .old_i      (state_q.stat),
        .kind_i     (op_kind),
        .bit_i      (op_bit),
        .nib_i      (op_nib),
        .imm_i      (op_imm),
        .nib_mask_i (nib_mask),
        .fld_mask_i (fld_mask),
        .data_i     (op_data[WORD_W-1:0]),
        .exc_i      (exc_flags),
        .cc_i       (cmp_cc),
        .base_o     (base_w),
        .cx_o       (cx_w),
        .copy_nib_o (copy_nib)
    );

    fstat_summary u_summary (
        .base_i  (base_w),
        .cx_i    (cx_w),
        .final_o (final_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.cr_we = 1'b0;
        state_d.trap  = 1'b0;
        if (op_valid) begin
            state_d.stat = final_w;
            state_d.trap = final_w[B_TRAP];
            case (op_kind_e'(op_kind))
                OPK_CMP: begin
                    state_d.cr_we  = 1'b1;
                    state_d.cr_fld = op_crf;
                    state_d.cr_nib = final_w[CC_LO +: NIB_W];
                end
                OPK_COPY: begin
                    state_d.cr_we  = 1'b1;
                    state_d.cr_fld = op_crf;
                    state_d.cr_nib = copy_nib;
                end
                OPK_RSVD: begin
                    state_d.cr_we  = 1'b0;
                end
                default: begin
                    if (op_rec) begin
                        state_d.cr_we  = 1'b1;
                        state_d.cr_fld = FLD_IDX_W'(CR_REC_FIELD);
                        state_d.cr_nib = final_w[WORD_W-1 -: NIB_W];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status   = state_q.stat;
    assign cr_we    = state_q.cr_we;
    assign cr_field = state_q.cr_fld;
    assign cr_data  = state_q.cr_nib;
    assign trap_req = state_q.trap;

endmodule

// File: rtl/fstat_unit_chk.sv
module fstat_unit_chk
    import fstat_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic        op_rec,
    input logic [31:0] status,
    input logic        cr_we,
    input logic        trap_req
);
    AST_INV_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |-> (status[B_INV] == |(status & INV_CAUSE_M)));  // R3

    AST_TRAP_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |-> (status[B_TRAP] == |(status[EN_HI:EN_LO] & status[SUM_LO+NUM_EN-1:SUM_LO])));  // R4

    AST_TRAP_REQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(op_valid) && status[B_TRAP]));  // R12

    AST_TRAP_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && status[B_TRAP]) |-> trap_req);  // R12

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(status) && !cr_we && !trap_req));  // R13

    AST_CR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($past(op_valid) && ($past(op_kind) == 3'd5 || $past(op_kind) == 3'd6 ||
                   ($past(op_rec) && $past(op_kind) != 3'd7))));  // R11
endmodule

bind fstat_unit fstat_unit_chk u_fstat_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_rec   (op_rec),
    .status   (status),
    .cr_we    (cr_we),
    .trap_req (trap_req)
);

// File: tb/fstat_unit_bench.sv
`timescale 1ns/1ps
module fstat_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [4:0]  op_bit = '0;
    logic [2:0]  op_nib = '0;
    logic [3:0]  op_imm = '0;
    logic [7:0]  op_fmask = '0;
    logic [63:0] op_data = '0;
    logic        op_rec = 1'b0;
    logic [2:0]  op_crf = '0;
    logic [31:0] exc_flags = '0;
    logic [3:0]  cmp_cc = '0;
    logic [31:0] status;
    logic        cr_we;
    logic [2:0]  cr_field;
    logic [3:0]  cr_data;
    logic        trap_req;

    typedef struct {
        logic [31:0] stat;
        logic        we;
        logic [2:0]  fld;
        logic [3:0]  nib;
        logic        trap;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] shadow   = '0;

    always #4 clk = ~clk;

    fstat_unit u_fstat_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_bit(op_bit), .op_nib(op_nib), .op_imm(op_imm), .op_fmask(op_fmask),
        .op_data(op_data), .op_rec(op_rec), .op_crf(op_crf), .exc_flags(exc_flags),
        .cmp_cc(cmp_cc), .status(status), .cr_we(cr_we), .cr_field(cr_field),
        .cr_data(cr_data), .trap_req(trap_req)
    );

    function automatic bit is_sticky_clr(int p);
        return (p == 31) || (p <= 28 && p >= 19) || (p <= 10 && p >= 8);
    endfunction

    function automatic exp_t model(logic [31:0] old, int kind, int bn, int nib, logic [3:0] imm,
                                   logic [7:0] fm, logic [63:0] data, bit rec, int crf,
                                   logic [31:0] flags, logic [3:0] cc, string tag);
        exp_t        e;
        logic [31:0] base = old;
        logic [31:0] cx   = '0;
        logic [31:0] w;
        logic [3:0]  copied = '0;
        bit          chg;
        case (kind)
            0: cx = flags;
            1: begin cx[31-bn] = 1'b1; cx[30] = 1'b0; cx[29] = 1'b0; end
            2: if ((31-bn) != 30 && (31-bn) != 29) base[31-bn] = 1'b0;
            3: for (int j = 0; j < 4; j++) base[31-4*nib-j] = imm[3-j];
            4: for (int i = 0; i < 8; i++)
                   if (fm[i]) for (int j = 0; j < 4; j++) base[4*i+j] = data[4*i+j];
            5: for (int j = 0; j < 4; j++) begin
                   copied[3-j] = old[31-4*nib-j];
                   if (is_sticky_clr(31-4*nib-j)) base[31-4*nib-j] = 1'b0;
               end
            6: begin base[15:12] = cc; cx = flags; end
            default: ;
        endcase
        w = base;
        w[30] = 1'b0;
        w[29] = 1'b0;
        w = w | cx;
        w[29] = (|w[24:19]) | (|w[10:8]);
        w[30] = (w[7] & w[29]) | (w[6] & w[28]) | (w[5] & w[27]) | (w[4] & w[26]) | (w[3] & w[25]);
        chg = (w[29:19] != base[29:19]) || (w[10:8] != base[10:8]);
        if (chg) w[31] = 1'b1;
        e.stat = w; e.trap = w[30]; e.we = 1'b0; e.fld = '0; e.nib = '0; e.tag = tag;
        if (kind == 6) begin e.we = 1'b1; e.fld = 3'(crf); e.nib = w[15:12]; end
        else if (kind == 5) begin e.we = 1'b1; e.fld = 3'(crf); e.nib = copied; end
        else if (rec && kind != 7) begin e.we = 1'b1; e.fld = 3'd1; e.nib = w[31:28]; end
        return e;
    endfunction

    task automatic issue(int kind, int bn, int nib, logic [3:0] imm, logic [7:0] fm,
                         logic [63:0] data, bit rec, int crf, logic [31:0] flags,
                         logic [3:0] cc, string tag);
        exp_t e;
        @(negedge clk);
        op_kind = 3'(kind); op_bit = 5'(bn); op_nib = 3'(nib); op_imm = imm;
        op_fmask = fm; op_data = data; op_rec = rec; op_crf = 3'(crf);
        exc_flags = flags; cmp_cc = cc;
        e = model(shadow, kind, bn, nib, imm, fm, data, rec, crf, flags, cc, tag);
        shadow = e.stat;
        sb_q.push_back(e);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic arith(logic [31:0] flags, bit rec, string tag);
        issue(0, 0, 0, 4'h0, 8'h00, 64'h0, rec, 0, flags, 4'h0, tag);
    endtask

    // monitor: compares the item issued in the cycle that just closed
    initial begin
        forever begin
            logic v;
            exp_t e;
            @(posedge clk);
            v = op_valid;
            #2;
            if (v) begin
                n_checks++;
                if (sb_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL scoreboard empty: result with no expected item");
                end else begin
                    e = sb_q.pop_front();
                    if (status !== e.stat || trap_req !== e.trap || cr_we !== e.we ||
                        (e.we && (cr_field !== e.fld || cr_data !== e.nib))) begin
                        n_fails++;
                        $display("FAIL %s: status=%h trap=%b cr_we=%b fld=%0d nib=%h expected status=%h trap=%b cr_we=%b fld=%0d nib=%h",
                                 e.tag, status, trap_req, cr_we, cr_field, cr_data,
                                 e.stat, e.trap, e.we, e.fld, e.nib);
                    end
                end
            end
        end
    end

    task automatic direct_check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        direct_check(status == 0 && !cr_we && !trap_req, "R1 in reset", status, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        direct_check(status == 0 && !cr_we && !trap_req, "R1 after release", status, 32'h0);

        arith(32'h1000_0000, 1'b0, "R2 overflow flag merge");
        arith(32'h0100_0000, 1'b0, "R3 invalid cause sets summary");
        issue(2, 0, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R5 clear any-change bit");
        arith(32'h0, 1'b0, "R5 no change keeps any-change clear");
        arith(32'h0000_0400, 1'b0, "R3 software invalid cause");
        issue(2, 2, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R6 clear invalid summary ignored");
        issue(1, 1, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R6 set trap summary ignored");
        issue(1, 24, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R4 invalid enable raises trap summary");
        issue(3, 0, 7, 4'h3, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R7 immediate nibble 7");
        issue(3, 0, 2, 4'hA, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R7 immediate nibble 2");
        issue(3, 0, 0, 4'hE, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R4 immediate into top nibble");
        issue(4, 0, 0, 4'h0, 8'hFF, 64'hDEAD_BEEF_0000_0000, 1'b0, 0, 32'h0, 4'h0, "R8 full mask zeroes word");
        issue(4, 0, 0, 4'h0, 8'h01, 64'hFFFF_FFFF_0000_000F, 1'b0, 0, 32'h0, 4'h0, "R8 low nibble only");
        issue(4, 0, 0, 4'h0, 8'h80, 64'h0000_0000_F000_0000, 1'b0, 0, 32'h0, 4'h0, "R3 written summaries discarded");
        issue(5, 0, 0, 4'h0, 8'h00, 64'h0, 1'b0, 5, 32'h0, 4'h0, "R9 copy top nibble");
        arith(32'h0900_0000, 1'b0, "R2 underflow and signalling cause");
        issue(5, 0, 1, 4'h0, 8'h00, 64'h0, 1'b0, 2, 32'h0, 4'h0, "R9 copy nibble 1 clears sticky");
        issue(4, 0, 0, 4'h0, 8'h10, 64'h0000_0000_000F_0000, 1'b0, 0, 32'h0, 4'h0, "R5 masked cause sets any-change");
        issue(5, 0, 3, 4'h0, 8'h00, 64'h0, 1'b0, 7, 32'h0, 4'h0, "R9 copy nibble 3 keeps non-sticky");
        issue(6, 0, 0, 4'h0, 8'h00, 64'h0, 1'b1, 3, 32'h0, 4'h2, "R10 compare code to field 3");
        issue(6, 0, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0008_0000, 4'h1, "R10 compare with invalid compare");
        arith(32'h0400_0000, 1'b1, "R11 record form to field 1");
        issue(1, 27, 0, 4'h0, 8'h00, 64'h0, 1'b1, 0, 32'h0, 4'h0, "R12 divide enable traps");
        arith(32'h0, 1'b0, "R12 sticky exception keeps trap");
        issue(2, 5, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R12 clear divide flag");
        issue(2, 12, 0, 4'h0, 8'h00, 64'h0, 1'b0, 0, 32'h0, 4'h0, "R12 clear invalid compare cause");

        // R13: inputs wiggle while the strobe is low
        @(negedge clk);
        begin
            logic [31:0] held;
            held = status;
            for (int c = 0; c < 4; c++) begin
                op_kind = 3'(c + 1); op_bit = 5'(c); op_fmask = 8'hFF;
                op_data = 64'h1234_5678_9ABC_DEF0; exc_flags = 32'hFFFF_FFFF; op_rec = 1'b1;
                @(negedge clk);
                direct_check(status == held && !cr_we && !trap_req, "R13 idle hold", status, held);
            end
        end

        repeat (3) @(negedge clk);
        direct_check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule